// File: doc/BRIEF.md
# Programmable Pseudorandom Bit Sequence Generator

This block produces a serial test pattern from a linear feedback shift register. Software chooses the register length (1 to 32 stages) and an arbitrary set of feedback taps through a 32-bit mask. A seed value is loaded into the register on a rising edge of a load strobe. Each enabled clock cycle sends one bit. When the enable is low, the block holds still.

Three controls shape the bit stream after it leaves the register. An optional run-limiting rule forces a one into the output whenever the fourteen bits that follow it would all be zero. This rule is meant for the 2^20 − 1 pattern. A one-shot error strobe complements exactly one outgoing bit. An inversion control complements the whole stream as the last stage. To apply the run-limiting rule, the block runs the register fifteen steps ahead of the output through a delay line. The first bit generated after a seed load therefore reaches the output fifteen transmitted bits later.

Top module: `prbs_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all state clears: register, delay line, strobe edge detectors, pending error and `dOut` (which reads 0).
- R2: On each advancing cycle, the register shifts one place towards its top stage. The new bit 0 is the XOR of every stage below the effective length whose `tapMask` bit is set. A maximal tap set (length 7, mask 0x60) gives a period of 127 bits.
- R3: A rising edge of `seedLoad`, sampled only in cycles with `clkEn` high, loads `seed` (trimmed to the length) into the register. That cycle sends no bit, and `dOut` holds.
- R4: The generated bit is stage (length−1). It appears on `dOut` after 15 further transmitted bits, with the register output first in the sequence.
- R5: With `zsEn` high, a transmitted bit is forced to 1 whenever the 14 generated bits behind it are all 0. As a result, no run of more than 14 zeros leaves the block.
- R6: With `invEn` high, every transmitted bit is complemented. Inversion is applied last and takes effect on the next transmitted bit.
- R7: Each rising edge of `errStrobe`, sampled only in cycles with `clkEn` high, complements exactly one transmitted bit. If the edge falls on a seed-load cycle, the flip waits for the next transmitted bit. Holding the strobe high produces no further errors.
- R8: With `clkEn` low, no state changes, the strobes are not sampled, and `dOut` keeps the last bit sent.
- R9: An all-zero seed gives a constant-zero stream once the delay line has flushed. The block does not correct it.
- R10: A `patLen` of 0, or a value above 32, acts as length 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| clkEn | input | 1 | Clock enable; low gaps the generator |
| tapMask | input | 32 | Feedback tap mask, bit i selects stage i |
| seed | input | 32 | Value loaded into the register |
| patLen | input | 6 | Register length, 1..32 (0 or >32 means 32) |
| seedLoad | input | 1 | Seed load request, rising edge active |
| zsEn | input | 1 | Enables the fourteen-zero run limit |
| invEn | input | 1 | Complements the transmitted stream |
| errStrobe | input | 1 | Single error request, rising edge active |
| dOut | output | 1 | Serial data, one bit per enabled cycle |

## Verification
Four stimulus families are used.

- A 7-stage maximal polynomial started from seed 1 shows both the fifteen-bit latency (the first one lands at a known position) and the 127-bit period, which separates a correct feedback path from a wrong tap or stage choice.
- A 20-stage pattern started from seed 1 begins with a long run of zeros. Run limiting must break that run, and the longest run of zeros observed shows whether the lookahead is placed correctly.
- An all-zero seed gives a flat stream. This makes single error flips, held strobes and load-cycle edges countable as isolated ones, and makes inversion visible as an all-ones stream.
- Runs at lengths 0, 32 and 40 must agree, and gapped cycles with strobes toggling must leave the output still.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  // Strobes from the control half to the datapath, valid for one cycle.
  typedef struct packed {
    logic advance;  // send one bit and step the register
    logic load;     // load the seed, send nothing
    logic flip;     // complement the bit sent in an advance cycle
  } prbs_strb_t;
endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clkEn,
  input  logic       seedLoad,
  input  logic       errStrobe,
  output prbs_strb_t strb
);
  logic prevLd, prevErr, errPend;
  logic ldRise, errRise;

  // Edges are judged against the level seen on the last enabled cycle.
  assign ldRise  = seedLoad  & ~prevLd;
  assign errRise = errStrobe & ~prevErr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prevLd  <= 1'b0;
      prevErr <= 1'b0;
      errPend <= 1'b0;
    end else if (clkEn) begin
      prevLd  <= seedLoad;
      prevErr <= errStrobe;
      // a requested flip survives a load cycle and is spent on the next bit
      errPend <= ldRise ? (errPend | errRise) : 1'b0;
    end
  end

  always_comb begin
    strb.load    = clkEn & ldRise;
    strb.advance = clkEn & ~ldRise;
    strb.flip    = errPend | errRise;
  end
endmodule

// File: rtl/prbs_dp.sv
module prbs_dp
  import prbs_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ZRUN  = 14,
  localparam int LEN_W = $clog2(REG_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  prbs_strb_t       strb,
  input  logic [REG_W-1:0] tapMask,
  input  logic [REG_W-1:0] seed,
  input  logic [LEN_W-1:0] patLen,
  input  logic             zsEn,
  input  logic             invEn,
  output logic             dOut,
  output logic [ZRUN:0]    lineView
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(REG_W);

  logic [REG_W-1:0] lfsr, lenMask, topSel, nextLfsr;
  logic [LEN_W-1:0] effLen;
  logic [ZRUN:0]    dLine;
  logic fbBit, genBit, headBit, runZero, shaped, txBit;

  assign effLen = (patLen == '0 || patLen > FULL_LEN) ? FULL_LEN : patLen;

  for (genvar i = 0; i < REG_W; i++) begin : g_stage
    assign lenMask[i] = LEN_W'(i) < effLen;
    assign topSel[i]  = LEN_W'(i + 1) == effLen;
  end

  assign fbBit    = ^(lfsr & tapMask & lenMask);
  assign genBit   = |(lfsr & topSel);
  assign nextLfsr = {lfsr[REG_W-2:0], fbBit} & lenMask;

  // Oldest entry of the line goes out; the ZRUN younger ones are the lookahead.
  assign headBit = dLine[ZRUN];
  assign runZero = ~|dLine[ZRUN-1:0];
  assign shaped  = headBit | (zsEn & runZero);
  assign txBit   = shaped ^ strb.flip ^ invEn;

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr  <= '0;
      dLine <= '0;
      dOut  <= 1'b0;
    end else if (strb.load) begin
      lfsr <= seed & lenMask;
    end else if (strb.advance) begin
      lfsr  <= nextLfsr;
      dLine <= {dLine[ZRUN-1:0], genBit};
      dOut  <= txBit;
    end
  end

  assign lineView = dLine;
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int ZRUN  = 14,
  localparam int LEN_W = $clog2(REG_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clkEn,
  input  logic [REG_W-1:0] tapMask,
  input  logic [REG_W-1:0] seed,
  input  logic [LEN_W-1:0] patLen,
  input  logic             seedLoad,
  input  logic             zsEn,
  input  logic             invEn,
  input  logic             errStrobe,
  output logic             dOut
);
  prbs_strb_t    strb;
  logic [ZRUN:0] lineView;

  prbs_ctrl u_ctrl (
    .clk(clk), .rst(rst), .clkEn(clkEn),
    .seedLoad(seedLoad), .errStrobe(errStrobe), .strb(strb)
  );

  prbs_dp #(.REG_W(REG_W), .ZRUN(ZRUN)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .tapMask(tapMask), .seed(seed),
    .patLen(patLen), .zsEn(zsEn), .invEn(invEn),
    .dOut(dOut), .lineView(lineView)
  );
endmodule

// File: rtl/prbs_gen_chk.sv
module prbs_gen_chk
  import prbs_pkg::*;
#(
  parameter int ZRUN = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          clkEn,
  input logic          zsEn,
  input logic          invEn,
  input logic          errStrobe,
  input logic          dOut,
  input prbs_strb_t    strb,
  input logic [ZRUN:0] lineView
);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !clkEn |=> $stable(dOut));

  p_load_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> $stable(dOut));

  p_force_one_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && zsEn && lineView[ZRUN-1:0] == '0 && !strb.flip && !invEn)
      |=> dOut);

  p_invert_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && invEn && !zsEn && !strb.flip && !lineView[ZRUN])
      |=> dOut);

  p_single_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (strb.advance && strb.flip && errStrobe) |=> !strb.flip);
endmodule

bind prbs_gen prbs_gen_chk #(.ZRUN(ZRUN)) u_chk (
  .clk(clk), .rst(rst), .clkEn(clkEn), .zsEn(zsEn), .invEn(invEn),
  .errStrobe(errStrobe), .dOut(dOut), .strb(strb), .lineView(lineView)
);

// File: tb/prbs_gen_bench.sv
`timescale 1ns/1ps
module prbs_gen_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, clkEn = 1'b0, seedLoad = 1'b0, zsEn = 1'b0, invEn = 1'b0, errStrobe = 1'b0;
  logic [31:0] tapMask = '0, seed = '0;
  logic [5:0]  patLen = 6'd7;
  logic        dOut;

  // staged settings, applied by the driver at the same edge the model uses
  logic        sRst = 1'b1, sZs = 1'b0, sInv = 1'b0;
  logic [31:0] sTap = '0, sSeed = '0;
  logic [5:0]  sLen = 6'd7;

  prbs_gen u_prbs_gen (
    .clk(clk), .rst(rst), .clkEn(clkEn), .tapMask(tapMask), .seed(seed),
    .patLen(patLen), .seedLoad(seedLoad), .zsEn(zsEn), .invEn(invEn),
    .errStrobe(errStrobe), .dOut(dOut)
  );

  typedef struct { logic exp; string tag; bit cap; } item_t;
  item_t sbq[$];
  logic  capQ[$];
  int nChecks = 0, nFail = 0;

  // reference model state
  logic [31:0] mS = '0;
  logic [14:0] mDl = '0;
  logic mOut = 1'b0, mPl = 1'b0, mPe = 1'b0, mPend = 1'b0;

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    int L;
    logic g, fb, ob, fl, ldE, erE;
    logic [31:0] msk;
    if (rst) begin
      mS = '0; mDl = '0; mOut = 0; mPl = 0; mPe = 0; mPend = 0;
      return;
    end
    if (!clkEn) return;
    L = (patLen == 0 || patLen > 32) ? 32 : int'(patLen);
    msk = '0;
    for (int i = 0; i < L; i++) msk[i] = 1'b1;
    ldE = seedLoad && !mPl;
    erE = errStrobe && !mPe;
    mPl = seedLoad; mPe = errStrobe;
    fl = mPend || erE;
    if (ldE) begin
      mS = seed & msk;
      mPend = fl;
    end else begin
      g = mS[L-1];
      fb = 1'b0;
      for (int i = 0; i < L; i++) fb ^= mS[i] & tapMask[i];
      ob = mDl[14];
      if (zsEn && mDl[13:0] == 14'd0) ob = 1'b1;
      mOut = ob ^ fl ^ invEn;
      mDl = {mDl[13:0], g};
      mS = ((mS << 1) | {31'd0, fb}) & msk;
      mPend = 1'b0;
    end
  endtask

  task automatic drive(input bit en, input bit ld, input bit er, input string tag, input bit cap = 0);
    item_t it;
    @(negedge clk);
    rst = sRst; tapMask = sTap; seed = sSeed; patLen = sLen; zsEn = sZs; invEn = sInv;
    clkEn = en; seedLoad = ld; errStrobe = er;
    modelStep();
    it.exp = mOut; it.tag = tag; it.cap = cap;
    sbq.push_back(it);
  endtask

  task automatic run(input int n, input string tag, input bit cap = 0);
    for (int i = 0; i < n; i++) drive(1, 0, 0, tag, cap);
  endtask

  task automatic drain();
    drive(0, 0, 0, "R8"); drive(0, 0, 0, "R8");
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // monitor: compares one expected item per clock, mid high phase
  initial forever begin
    item_t it;
    @(posedge clk); #1;
    if (sbq.size() > 0) begin
      it = sbq.pop_front();
      check(it.tag, dOut, it.exp);
      if (it.cap) capQ.push_back(dOut);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired (all requirements) actual=running expected=done");
    finishRun();
  end

  initial begin
    logic ref32[$];
    int cnt, runLen, maxRun;
    // R1: reset state
    repeat (3) drive(0, 0, 0, "R1");
    repeat (2) drive(1, 1, 1, "R1");
    sRst = 1'b0;
    drive(0, 0, 0, "R1");

    // R2/R4: seven stage maximal polynomial from seed 1
    sLen = 6'd7; sTap = 32'h60; sSeed = 32'd1;
    drive(1, 1, 0, "R3");
    run(300, "R2", 1);
    drain();
    for (int k = 0; k < 21; k++) check("R4 leading zeros", capQ[k], 1'b0);
    check("R4 first one position", capQ[21], 1'b1);
    for (int k = 15; k < 173; k++) check("R2 period 127", capQ[k + 127], capQ[k]);
    capQ.delete();

    // R5: twenty stage pattern with run limit
    sLen = 6'd20; sTap = (32'd1 << 19) | (32'd1 << 16); sSeed = 32'd1; sZs = 1'b1;
    drive(1, 0, 0, "R3"); drive(1, 1, 0, "R3");
    run(250, "R5", 1);
    drain();
    runLen = 0; maxRun = 0;
    foreach (capQ[k]) begin
      runLen = capQ[k] ? 0 : runLen + 1;
      if (runLen > maxRun) maxRun = runLen;
    end
    check("R5 longest zero run <= 14", maxRun <= 14, 1'b1);
    capQ.delete();

    // R9: all-zero seed, then R6 inversion of the flat stream
    sZs = 1'b0; sLen = 6'd32; sTap = 32'h80200003; sSeed = 32'd0;
    drive(1, 0, 0, "R3"); drive(1, 1, 0, "R3");
    run(40, "R9");
    sInv = 1'b1; run(20, "R6");
    sInv = 1'b0; run(5, "R6");

    // R7: held strobe flips once; edge on a load cycle flips the next bit
    drive(1, 1, 1, "R7");
    for (int i = 0; i < 6; i++) drive(1, 1, 1, "R7", 1);
    drive(1, 0, 0, "R7", 1);
    run(10, "R7", 1);
    drive(1, 0, 1, "R7", 1);
    run(10, "R7", 1);
    drain();
    cnt = 0;
    foreach (capQ[k]) cnt += int'(capQ[k]);
    check("R7 two isolated error bits", cnt == 2, 1'b1);
    capQ.delete();

    // R8: gapped cycles with strobes toggling
    sSeed = 32'h1234_5677; sTap = 32'h8000_0057;
    drive(1, 0, 0, "R8");
    drive(1, 1, 0, "R3");
    run(20, "R8");
    for (int i = 0; i < 8; i++) drive(0, i[0], i[1], "R8");
    sInv = 1'b1; drive(0, 0, 0, "R8"); sInv = 1'b0;
    drive(0, 0, 0, "R8");
    run(20, "R8");

    // R10: lengths 32, 0 and 40 give the same stream
    sSeed = 32'hACE1_0F35; sTap = 32'h8000_0057;
    for (int pass = 0; pass < 3; pass++) begin
      sLen = (pass == 0) ? 6'd32 : (pass == 1) ? 6'd0 : 6'd40;
      drive(1, 0, 0, "R10"); drive(1, 1, 0, "R10");
      run(60, "R10", 1);
      drain();
      if (pass == 0) begin
        ref32 = capQ;
      end else begin
        for (int k = 15; k < 60; k++) check("R10 length alias", capQ[k], ref32[k]);
      end
      capQ.delete();
    end

    drain();
    finishRun();
  end
endmodule